// File: doc/BRIEF.md
# PLL Rate-Change Sequencer

This block moves a PLL to a new output frequency when it is asked to. A request carries a target rate in hertz. The block compares that rate against a small built-in table of divider settings and accepts only an exact match. On a match it packs the PLL control word and writes it. It then waits a fixed relock interval and reads the PLL status once. A done pulse reports the outcome as a two-bit result code.

The table is picked by a parameter. One table holds general-purpose rates. The other holds video rates, and one of its entries bypasses the PLL rather than locking it.

A second parameter marks the instance as the core PLL. A core instance also steps a separate interface-clock divider around the change. The interface clock is therefore never run too fast, whether the core clock is rising or falling.

All register traffic uses one-cycle read and write strobes with an address. Read data is taken in the same cycle as the read strobe.

Top module: `pll_rate_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `busy`, `done`, `reg_wr` and `reg_rd` are all low.
- R2: A rate that equals no table entry ends with result code 3 (invalid rate), and no register is written or read.
- R3: A normal entry is written to address 0 as a control word built from zero: output divider in bits 3:2, input divider in bits 8:4, feedback divider in bits 15:9, band in bits 23:20, and bits 0 (power-down) and 1 (bypass) both clear. For example, 1 GHz gives 0x3A10, 100 MHz gives 0x160C and 148.5 MHz gives 0x2A0C.
- R4: A bypass entry first reads address 0, then writes back that same value with only bit 1 set. Exactly one control read occurs.
- R5: The status read (address 1) comes exactly LOCK_CYCLES+1 clock cycles after the control write. LOCK_CYCLES is CLK_HZ/1e6 × LOCK_US.
- R6: Status bit 0 is lock and status bit 1 is error. If lock is clear the result is 1 (timeout). If lock is set and error is set the result is 2 (bad configuration). Otherwise the result is 0.
- R7: On a core instance, a rate above THRESH_HZ writes 1 (divide-by-2) to the interface divider (address 2). That write comes before the control write. A rate equal to THRESH_HZ causes no such early write.
- R8: On a core instance, a rate at or below THRESH_HZ writes 0 (divide-by-1) to address 2, and only after a status read that gives result 0. On any failure, address 2 is not written.
- R9: `busy` rises the cycle after a request is accepted and stays high through the done cycle. A request made while busy is ignored.
- R10: `done` is high for exactly one cycle per accepted request. `err_code` is valid in that cycle.
- R11: An instance that is not a core instance never writes address 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Rate-change request strobe |
| req_rate_hz | input | 32 | Requested output rate in Hz |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 timeout, 2 bad configuration, 3 invalid rate |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_addr | output | 2 | 0 control, 1 status, 2 interface divider |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data, valid in the strobe cycle |

## Verification
The hardest case to reach is the interface-divider ordering. The order depends on the relative timing of three accesses, and on whether the request crosses the threshold in either direction. It also depends on whether the lock then succeeds.

The bench pairs each instance with a register model that records the cycle of every divider write, control write and status read. Between requests it changes the lock and error flags that the model returns. It runs an upward step, a failed downward step, a successful downward step and an exact-threshold step. It then compares the recorded stamps and the divider value that each step leaves behind.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_PRE_DIV,
        ST_RD_CTRL,
        ST_WR_CTRL,
        ST_WAIT,
        ST_RD_STAT,
        ST_POST_DIV,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        RES_OK       = 2'd0,
        RES_TIMEOUT  = 2'd1,
        RES_BAD_CFG  = 2'd2,
        RES_BAD_RATE = 2'd3
    } seq_result_e;

    typedef struct packed {
        logic [31:0] rate_hz;
        logic [4:0]  in_div;
        logic [6:0]  fb_div;
        logic [1:0]  out_div;
        logic [3:0]  band;
        logic        bypass;
    } pll_setting_t;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_STAT  = 2'd1;
    localparam logic [1:0] ADDR_IFDIV = 2'd2;

    localparam int BIT_PWRDN   = 0;
    localparam int BIT_BYPASS  = 1;
    localparam int LSB_OUT_DIV = 2;
    localparam int LSB_IN_DIV  = 4;
    localparam int LSB_FB_DIV  = 9;
    localparam int LSB_BAND    = 20;

    localparam int STAT_LOCK = 0;
    localparam int STAT_ERR  = 1;

    localparam int GENERAL_ENTRIES = 19;
    localparam int VIDEO_ENTRIES   = 5;

    function automatic pll_setting_t mk_set(input logic [31:0] r, input int i,
                                            input int f, input int o, input logic b);
        pll_setting_t s;
        s.rate_hz = r;
        s.in_div  = 5'(i);
        s.fb_div  = 7'(f);
        s.out_div = 2'(o);
        s.band    = 4'd0;
        s.bypass  = b;
        return s;
    endfunction

    function automatic pll_setting_t general_entry(input int idx);
        case (idx)
            0:  return mk_set(32'd100_000_000,  0, 11, 3, 1'b0);
            1:  return mk_set(32'd133_000_000,  0, 15, 3, 1'b0);
            2:  return mk_set(32'd200_000_000,  1, 47, 3, 1'b0);
            3:  return mk_set(32'd233_000_000,  1, 27, 2, 1'b0);
            4:  return mk_set(32'd300_000_000,  1, 35, 2, 1'b0);
            5:  return mk_set(32'd333_000_000,  1, 39, 2, 1'b0);
            6:  return mk_set(32'd400_000_000,  1, 47, 2, 1'b0);
            7:  return mk_set(32'd500_000_000,  0, 14, 1, 1'b0);
            8:  return mk_set(32'd600_000_000,  0, 17, 1, 1'b0);
            9:  return mk_set(32'd700_000_000,  0, 20, 1, 1'b0);
            10: return mk_set(32'd800_000_000,  0, 23, 1, 1'b0);
            11: return mk_set(32'd900_000_000,  1, 26, 0, 1'b0);
            12: return mk_set(32'd1000_000_000, 1, 29, 0, 1'b0);
            13: return mk_set(32'd1100_000_000, 1, 32, 0, 1'b0);
            14: return mk_set(32'd1200_000_000, 1, 35, 0, 1'b0);
            15: return mk_set(32'd1300_000_000, 1, 38, 0, 1'b0);
            16: return mk_set(32'd1400_000_000, 1, 41, 0, 1'b0);
            17: return mk_set(32'd1500_000_000, 1, 44, 0, 1'b0);
            18: return mk_set(32'd1600_000_000, 1, 47, 0, 1'b0);
            default: return '0;
        endcase
    endfunction

    function automatic pll_setting_t video_entry(input int idx);
        case (idx)
            0: return mk_set(32'd27_000_000,  0,  0, 0, 1'b1);
            1: return mk_set(32'd148_500_000, 0, 21, 3, 1'b0);
            2: return mk_set(32'd297_000_000, 0, 21, 2, 1'b0);
            3: return mk_set(32'd540_000_000, 0, 19, 1, 1'b0);
            4: return mk_set(32'd594_000_000, 0, 21, 1, 1'b0);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/pll_rate_table.sv
module pll_rate_table
    import pll_seq_pkg::*;
#(
    parameter int TABLE_SEL = 0
) (
    input  logic [31:0]  rate_hz,
    output logic         hit,
    output pll_setting_t setting
);
    localparam int N = (TABLE_SEL == 0) ? GENERAL_ENTRIES : VIDEO_ENTRIES;

    pll_setting_t ent [N];

    for (genvar gi = 0; gi < N; gi++) begin : g_ent
        if (TABLE_SEL == 0) begin : g_gen
            assign ent[gi] = general_entry(gi);
        end else begin : g_vid
            assign ent[gi] = video_entry(gi);
        end
    end

    always_comb begin
        hit     = 1'b0;
        setting = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (ent[i].rate_hz == rate_hz) begin
                hit     = 1'b1;
                setting = ent[i];
            end
        end
    end
endmodule

// File: rtl/pll_ctrl_pack.sv
module pll_ctrl_pack
    import pll_seq_pkg::*;
(
    input  pll_setting_t setting,
    input  logic [31:0]  cur_ctrl,
    output logic [31:0]  word
);
    always_comb begin
        if (setting.bypass) begin
            word             = cur_ctrl;
            word[BIT_BYPASS] = 1'b1;
        end else begin
            word = '0;
            word[LSB_OUT_DIV +: 2] = setting.out_div;
            word[LSB_IN_DIV  +: 5] = setting.in_div;
            word[LSB_FB_DIV  +: 7] = setting.fb_div;
            word[LSB_BAND    +: 4] = setting.band;
        end
    end
endmodule

// File: rtl/pll_rate_seq.sv
module pll_rate_seq
    import pll_seq_pkg::*;
#(
    parameter int          CLK_HZ    = 250_000_000,
    parameter int          LOCK_US   = 100,
    parameter int          TABLE_SEL = 0,
    parameter bit          CORE_PLL  = 1'b1,
    parameter logic [31:0] THRESH_HZ = 32'd500_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [31:0] req_rate_hz,
    output logic        busy,
    output logic        done,
    output logic [1:0]  err_code,
    output logic        reg_wr,
    output logic        reg_rd,
    output logic [1:0]  reg_addr,
    output logic [31:0] reg_wdata,
    input  logic [31:0] reg_rdata
);
    localparam int LOCK_CYCLES = (CLK_HZ / 1_000_000) * LOCK_US;
    localparam int CNT_W       = $clog2(LOCK_CYCLES + 1);

    typedef struct packed {
        seq_state_e   state;
        logic [31:0]  rate;
        pll_setting_t setting;
        logic [31:0]  ctrl_rd;
        logic [CNT_W-1:0] cnt;
        seq_result_e  result;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic         tbl_hit;
    pll_setting_t tbl_set;
    logic [31:0]  ctrl_word;
    logic         rate_high;

    pll_rate_table #(.TABLE_SEL(TABLE_SEL)) i_table (
        .rate_hz (r_q.rate),
        .hit     (tbl_hit),
        .setting (tbl_set)
    );

    pll_ctrl_pack i_pack (
        .setting  (r_q.setting),
        .cur_ctrl (r_q.ctrl_rd),
        .word     (ctrl_word)
    );

    assign rate_high = (r_q.rate > THRESH_HZ);

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.rate  = req_rate_hz;
                    r_d.state = ST_LOOKUP;
                end
            end
            ST_LOOKUP: begin
                if (!tbl_hit) begin
                    r_d.result = RES_BAD_RATE;
                    r_d.state  = ST_DONE;
                end else begin
                    r_d.setting = tbl_set;
                    if (CORE_PLL && rate_high) r_d.state = ST_PRE_DIV;
                    else if (tbl_set.bypass)   r_d.state = ST_RD_CTRL;
                    else                       r_d.state = ST_WR_CTRL;
                end
            end
            ST_PRE_DIV: begin
                r_d.state = r_q.setting.bypass ? ST_RD_CTRL : ST_WR_CTRL;
            end
            ST_RD_CTRL: begin
                r_d.ctrl_rd = reg_rdata;
                r_d.state   = ST_WR_CTRL;
            end
            ST_WR_CTRL: begin
                r_d.cnt   = '0;
                r_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (r_q.cnt == CNT_W'(LOCK_CYCLES - 1)) r_d.state = ST_RD_STAT;
                else r_d.cnt = r_q.cnt + 1'b1;
            end
            ST_RD_STAT: begin
                if (!reg_rdata[STAT_LOCK]) begin
                    r_d.result = RES_TIMEOUT;
                    r_d.state  = ST_DONE;
                end else if (reg_rdata[STAT_ERR]) begin
                    r_d.result = RES_BAD_CFG;
                    r_d.state  = ST_DONE;
                end else begin
                    r_d.result = RES_OK;
                    r_d.state  = (CORE_PLL && !rate_high) ? ST_POST_DIV : ST_DONE;
                end
            end
            ST_POST_DIV: r_d.state = ST_DONE;
            ST_DONE:     r_d.state = ST_IDLE;
            default:     r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.state  <= ST_IDLE;
            r_q.result <= RES_OK;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        reg_wr    = 1'b0;
        reg_rd    = 1'b0;
        reg_addr  = ADDR_CTRL;
        reg_wdata = '0;
        case (r_q.state)
            ST_PRE_DIV: begin
                reg_wr    = 1'b1;
                reg_addr  = ADDR_IFDIV;
                reg_wdata = 32'd1;
            end
            ST_RD_CTRL: begin
                reg_rd   = 1'b1;
                reg_addr = ADDR_CTRL;
            end
            ST_WR_CTRL: begin
                reg_wr    = 1'b1;
                reg_addr  = ADDR_CTRL;
                reg_wdata = ctrl_word;
            end
            ST_RD_STAT: begin
                reg_rd   = 1'b1;
                reg_addr = ADDR_STAT;
            end
            ST_POST_DIV: begin
                reg_wr    = 1'b1;
                reg_addr  = ADDR_IFDIV;
                reg_wdata = 32'd0;
            end
            default: ;
        endcase
    end

    assign busy     = (r_q.state != ST_IDLE);
    assign done     = (r_q.state == ST_DONE);
    assign err_code = r_q.result;
endmodule

// File: rtl/pll_rate_seq_chk.sv
module pll_rate_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic [1:0]  err_code,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !reg_wr && !reg_rd));

    assert_no_access_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!reg_wr && !reg_rd));

    assert_ctrl_word_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && !reg_wdata[1]) |-> !reg_wdata[0]);

    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

    assert_ifdiv_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2) |-> (reg_wdata[31:1] == 31'd0));

    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_done_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_no_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!reg_wr && !reg_rd && err_code <= 2'd3));
endmodule

bind pll_rate_seq pll_rate_seq_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .err_code  (err_code),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata)
);

// File: tb/pll_reg_model.sv
module pll_reg_model (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic        rd,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        lock_in,
    input  logic        err_in,
    output logic [31:0] ctrl_q,
    output logic [31:0] div_q,
    output int          n_wr_ctrl,
    output int          n_wr_div,
    output int          n_rd_ctrl,
    output int          n_rd_stat,
    output longint      t_wr_ctrl,
    output longint      t_wr_div,
    output longint      t_rd_stat
);
    longint cyc;

    always_comb begin
        case (addr)
            2'd0:    rdata = ctrl_q;
            2'd1:    rdata = {30'd0, err_in, lock_in};
            2'd2:    rdata = div_q;
            default: rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc <= 0; ctrl_q <= 32'h1; div_q <= 32'h0;
            n_wr_ctrl <= 0; n_wr_div <= 0; n_rd_ctrl <= 0; n_rd_stat <= 0;
            t_wr_ctrl <= -1; t_wr_div <= -1; t_rd_stat <= -1;
        end else begin
            cyc <= cyc + 1;
            if (wr && addr == 2'd0) begin
                ctrl_q <= wdata; n_wr_ctrl <= n_wr_ctrl + 1; t_wr_ctrl <= cyc;
            end
            if (wr && addr == 2'd2) begin
                div_q <= wdata; n_wr_div <= n_wr_div + 1; t_wr_div <= cyc;
            end
            if (rd && addr == 2'd0) n_rd_ctrl <= n_rd_ctrl + 1;
            if (rd && addr == 2'd1) begin
                n_rd_stat <= n_rd_stat + 1; t_rd_stat <= cyc;
            end
        end
    end
endmodule

// File: tb/test_pll_rate_seq.sv
module test_pll_rate_seq;
    localparam int LOCK_US = 2;
    localparam int CLK_HZ  = 250_000_000;
    localparam int LCYC    = (CLK_HZ / 1_000_000) * LOCK_US;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [31:0] req_rate = '0;
    logic        req_c = 1'b0, req_v = 1'b0;
    logic        lock_c = 1'b1, err_c = 1'b0, lock_v = 1'b1, err_v = 1'b0;

    logic busy_c, done_c, wr_c, rd_c;
    logic [1:0] code_c, addr_c;
    logic [31:0] wd_c, rdat_c;
    logic busy_v, done_v, wr_v, rd_v;
    logic [1:0] code_v, addr_v;
    logic [31:0] wd_v, rdat_v;

    logic [31:0] ctrl_c, div_c, ctrl_v, div_v;
    int nwc_c, nwd_c, nrc_c, nrs_c, nwc_v, nwd_v, nrc_v, nrs_v;
    longint twc_c, twd_c, trs_c, twc_v, twd_v, trs_v;

    int errors = 0;
    int checks = 0;

    pll_rate_seq #(.CLK_HZ(CLK_HZ), .LOCK_US(LOCK_US), .TABLE_SEL(0), .CORE_PLL(1'b1))
    i_pll_rate_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_c), .req_rate_hz(req_rate),
        .busy(busy_c), .done(done_c), .err_code(code_c), .reg_wr(wr_c), .reg_rd(rd_c),
        .reg_addr(addr_c), .reg_wdata(wd_c), .reg_rdata(rdat_c)
    );

    pll_rate_seq #(.CLK_HZ(CLK_HZ), .LOCK_US(LOCK_US), .TABLE_SEL(1), .CORE_PLL(1'b0))
    i_pll_rate_seq_vid (
        .clk(clk), .rst_n(rst_n), .req_valid(req_v), .req_rate_hz(req_rate),
        .busy(busy_v), .done(done_v), .err_code(code_v), .reg_wr(wr_v), .reg_rd(rd_v),
        .reg_addr(addr_v), .reg_wdata(wd_v), .reg_rdata(rdat_v)
    );

    pll_reg_model i_model_c (
        .clk(clk), .rst_n(rst_n), .wr(wr_c), .rd(rd_c), .addr(addr_c), .wdata(wd_c),
        .rdata(rdat_c), .lock_in(lock_c), .err_in(err_c), .ctrl_q(ctrl_c), .div_q(div_c),
        .n_wr_ctrl(nwc_c), .n_wr_div(nwd_c), .n_rd_ctrl(nrc_c), .n_rd_stat(nrs_c),
        .t_wr_ctrl(twc_c), .t_wr_div(twd_c), .t_rd_stat(trs_c)
    );

    pll_reg_model i_model_v (
        .clk(clk), .rst_n(rst_n), .wr(wr_v), .rd(rd_v), .addr(addr_v), .wdata(wd_v),
        .rdata(rdat_v), .lock_in(lock_v), .err_in(err_v), .ctrl_q(ctrl_v), .div_q(div_v),
        .n_wr_ctrl(nwc_v), .n_wr_div(nwd_v), .n_rd_ctrl(nrc_v), .n_rd_stat(nrs_v),
        .t_wr_ctrl(twc_v), .t_wr_div(twd_v), .t_rd_stat(trs_v)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input bit vid, input logic [31:0] rate);
        @(negedge clk);
        req_rate = rate;
        if (vid) req_v = 1'b1; else req_c = 1'b1;
        @(negedge clk);
        req_v = 1'b0;
        req_c = 1'b0;
    endtask

    task automatic wait_done(input bit vid, output logic [1:0] code);
        int n = 0;
        while ((vid ? done_v : done_c) !== 1'b1 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        code = vid ? code_v : code_c;
        chk("R10 done seen", (vid ? done_v : done_c), 1);
        @(negedge clk);
        chk("R10 done one cycle", (vid ? done_v : done_c), 0);
    endtask

    task automatic t_reset;
        chk("R1 busy", busy_c, 0);
        chk("R1 done", done_c, 0);
        chk("R1 strobes", {wr_c, rd_c, wr_v, rd_v}, 0);
    endtask

    task automatic t_bad_rate;
        logic [1:0] code;
        int w0 = nwc_c + nwd_c + nrc_c + nrs_c;
        issue(1'b0, 32'd123_000_000);
        wait_done(1'b0, code);
        chk("R2 invalid rate code", code, 3);
        chk("R2 no accesses", nwc_c + nwd_c + nrc_c + nrs_c, w0);
    endtask

    task automatic t_raise;
        logic [1:0] code;
        lock_c = 1'b1; err_c = 1'b0;
        issue(1'b0, 32'd1000_000_000);
        repeat (10) @(negedge clk);
        chk("R9 busy mid sequence", busy_c, 1);
        req_rate = 32'd100_000_000;
        req_c = 1'b1;
        @(negedge clk);
        req_c = 1'b0;
        wait_done(1'b0, code);
        chk("R6 ok code", code, 0);
        chk("R3 ctrl word 1GHz", ctrl_c, 32'h3A10);
        chk("R7 div set to 2", div_c, 1);
        chk("R7 div before ctrl", (twd_c < twc_c) ? 1 : 0, 1);
        chk("R5 relock wait", trs_c - twc_c, LCYC + 1);
        chk("R9 ignored request", nwc_c, 1);
        repeat (3) @(negedge clk);
        chk("R9 idle after", busy_c, 0);
    endtask

    task automatic t_lower_fail;
        logic [1:0] code;
        int d0 = nwd_c;
        lock_c = 1'b0; err_c = 1'b0;
        issue(1'b0, 32'd100_000_000);
        wait_done(1'b0, code);
        chk("R6 timeout code", code, 1);
        chk("R3 ctrl word 100MHz", ctrl_c, 32'h160C);
        chk("R8 no div write on fail", nwd_c, d0);
        chk("R8 div held", div_c, 1);
    endtask

    task automatic t_lower_ok;
        logic [1:0] code;
        lock_c = 1'b1; err_c = 1'b0;
        issue(1'b0, 32'd100_000_000);
        wait_done(1'b0, code);
        chk("R6 ok code low", code, 0);
        chk("R8 div restored", div_c, 0);
        chk("R8 div after status", (twd_c > trs_c) ? 1 : 0, 1);
    endtask

    task automatic t_threshold_cfg_err;
        logic [1:0] code;
        int d0 = nwd_c;
        lock_c = 1'b1; err_c = 1'b1;
        issue(1'b0, 32'd500_000_000);
        wait_done(1'b0, code);
        chk("R6 bad cfg code", code, 2);
        chk("R3 ctrl word 500MHz", ctrl_c, 32'h1C04);
        chk("R7 no early div at threshold", nwd_c, d0);
        err_c = 1'b0;
    endtask

    task automatic t_video;
        logic [1:0] code;
        issue(1'b1, 32'd148_500_000);
        wait_done(1'b1, code);
        chk("R3 ctrl word 148.5MHz", ctrl_v, 32'h2A0C);
        chk("R11 no div write", nwd_v, 0);
        issue(1'b1, 32'd27_000_000);
        wait_done(1'b1, code);
        chk("R4 bypass rmw", ctrl_v, 32'h2A0E);
        chk("R4 one ctrl read", nrc_v, 1);
        chk("R4 ok code", code, 0);
        chk("R11 still no div write", nwd_v, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bad_rate();
        t_raise();
        t_lower_fail();
        t_lower_ok();
        t_threshold_cfg_err();
        t_video();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule